// File: doc/BRIEF.md
# Pulse-Swallow Divider Core with Serial Word Load

This block is the digital heart of a frequency synthesizer loop. A 17-bit divide word is shifted in over three lines (shift clock, data, load strobe) and takes effect only when the strobe rises. The word holds a swallow count A and a main count N. From them the block drives the modulus-control line of an external dual-modulus prescaler, which in turn is fed by the halved VCO. During the first A prescaler cycles of every N-cycle frame the line asks for the higher modulus. At the end of each frame the block emits a one-cycle frame tick.

A reference divider runs from the 6.4 MHz crystal clock that also clocks the block. It produces a comparison tick at 6.25 kHz (divide by 1024) or at 5 kHz (divide by 128, then by a further 10). A step-select input picks between the two. A tri-state phase-frequency detector compares the reference tick with the frame tick and drives up, down, or neither. A lock detector watches the width of the detector pulses against a programmable threshold.

Top module: `synth_divider_core`

## Requirements
- R1: Bits are sampled on each rising edge of `ser_clk`, most significant bit first. Shifting bits without a rising `ser_stb` changes neither the modulus pattern nor the lock state.
- R2: The word layout is N in bits 16:7 and A in bits 6:0. On a rising `ser_stb` the word is accepted only when N ≥ 1 and N ≥ A. Any other word is ignored: the running pattern continues and `locked` is kept.
- R3: Prescaler edges are counted from 0 within a frame of N edges. Before edge k of the frame is counted, `mod_hi` is 1 exactly when k < A. `frame_tick` pulses for one cycle after the N-th edge of each frame.
- R4: An accepted word clears `locked`, `pfd_up` and `pfd_dn`. It also restarts the frame count and the reference divider in the following cycle.
- R5: `ref_tick` is a one-cycle pulse. Its period is 1024 clock cycles when `step_fine` = 1 and 1280 cycles (128 × 10) when `step_fine` = 0.
- R6: A `ref_tick` arriving first raises `pfd_up`, and a `frame_tick` arriving first raises `pfd_dn`. The later tick clears both. `pfd_up` and `pfd_dn` are never high together, and `pfd_up` stays high while frame ticks are absent.
- R7: `locked` rises, in the cycle after a `ref_tick`, once 8 consecutive reference periods have passed with no detector pulse longer than `lock_thresh` cycles. With mismatched frequencies it never rises.
- R8: `locked` falls in the cycle after a detector pulse grows beyond `lock_thresh` cycles.
- R9: After reset, `mod_hi`, `frame_tick`, `ref_tick`, `pfd_up`, `pfd_dn` and `locked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock, 6.4 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, rising edge samples data |
| ser_data | input | 1 | Serial data, MSB first |
| ser_stb | input | 1 | Load strobe, rising edge applies the word |
| step_fine | input | 1 | 1: 6.25 kHz comparison, 0: 5 kHz |
| pre_in | input | 1 | Prescaler output, rising edges counted |
| lock_thresh | input | TH_W | Largest detector pulse width accepted as locked |
| mod_hi | output | 1 | Modulus control, 1 selects the higher modulus |
| frame_tick | output | 1 | One-cycle pulse at the end of each N frame |
| ref_tick | output | 1 | One-cycle reference comparison pulse |
| pfd_up | output | 1 | Detector pump-up drive |
| pfd_dn | output | 1 | Detector pump-down drive |
| locked | output | 1 | Lock indication |

## Verification
The modulus pattern is exercised with two swallow counts (5 and 20) and with frame lengths of 64 and 60. These cases separate a correct frame restart from a free-running count and show whether A or N is taken from the right field. A frequency-matched prescaler stream tells a lock detector that counts good periods apart from one that ignores them. A 60-cycle frame, a tiny threshold and a stalled prescaler each show whether the loop correctly fails to lock, drops lock, or holds only the up drive. An invalid word and a strobe-less shift are sent while a locked stream is running; they tell ignored words apart from words that are wrongly applied.

// File: rtl/synth_pkg.sv
package synth_pkg;
    localparam int A_W    = 7;
    localparam int N_W    = 10;
    localparam int WORD_W = A_W + N_W;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } div_word_t;

    localparam div_word_t RESET_WORD = '{n: N_W'(1), a: '0};

    function automatic logic word_ok(div_word_t w);
        return (w.n != '0) && (w.n >= {{(N_W-A_W){1'b0}}, w.a});
    endfunction
endpackage

// File: rtl/synth_ser_loader.sv
module synth_ser_loader import synth_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_clk,
    input  logic      ser_data,
    input  logic      ser_stb,
    output div_word_t word,
    output logic      load
);
    logic              sclk_q, stb_q;
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            stb_q  <= 1'b0;
            shreg  <= '0;
            word   <= RESET_WORD;
            load   <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
            stb_q  <= ser_stb;
            load   <= 1'b0;
            if (ser_clk && !sclk_q)
                shreg <= {shreg[WORD_W-2:0], ser_data};
            if (ser_stb && !stb_q && word_ok(div_word_t'(shreg))) begin
                word <= div_word_t'(shreg);
                load <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int COARSE_DIV = 128,
    parameter int FINE_DIV   = 1024,
    parameter int POST_DIV   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step_fine,
    output logic tick
);
    localparam int MAXD = (FINE_DIV > COARSE_DIV) ? FINE_DIV : COARSE_DIV;
    localparam int C1_W = $clog2(MAXD);
    localparam int C2_W = $clog2(POST_DIV);

    logic [C1_W-1:0] c1, lim1;
    logic [C2_W-1:0] c2;

    assign lim1 = step_fine ? C1_W'(FINE_DIV - 1) : C1_W'(COARSE_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            c1   <= '0;
            c2   <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (c1 >= lim1) begin
                c1 <= '0;
                if (step_fine) begin
                    tick <= 1'b1;
                end else if (c2 >= C2_W'(POST_DIV - 1)) begin
                    c2   <= '0;
                    tick <= 1'b1;
                end else begin
                    c2 <= c2 + 1'b1;
                end
            end else begin
                c1 <= c1 + 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_swallow.sv
module synth_swallow import synth_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      pre_in,
    input  div_word_t word,
    output logic      mod_hi,
    output logic      frame_tick
);
    logic           pre_q;
    logic [N_W-1:0] cnt;
    logic           pre_edge, last;

    assign pre_edge = pre_in && !pre_q;
    assign last     = ({1'b0, cnt} + 1'b1) >= {1'b0, word.n};
    assign mod_hi   = cnt < {{(N_W-A_W){1'b0}}, word.a};

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q      <= 1'b0;
            cnt        <= '0;
            frame_tick <= 1'b0;
        end else begin
            pre_q      <= pre_in;
            frame_tick <= 1'b0;
            if (load) begin
                cnt <= '0;
            end else if (pre_edge) begin
                if (last) begin
                    cnt        <= '0;
                    frame_tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/synth_pfd_lock.sv
module synth_pfd_lock #(
    parameter int TH_W         = 8,
    parameter int LOCK_PERIODS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            ref_tick,
    input  logic            var_tick,
    input  logic [TH_W-1:0] thresh,
    output logic            up,
    output logic            dn,
    output logic            locked
);
    localparam int G_W = $clog2(LOCK_PERIODS + 1);

    logic            up_n, dn_n, active, over, bad;
    logic [TH_W:0]   run;
    logic [G_W-1:0]  good;

    assign up_n   = up | ref_tick;
    assign dn_n   = dn | var_tick;
    assign active = up | dn;
    assign over   = active && (run >= {1'b0, thresh});

    always_ff @(posedge clk) begin
        if (rst || load) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else if (up_n && dn_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_n;
            dn <= dn_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            run    <= '0;
            good   <= '0;
            bad    <= 1'b0;
            locked <= 1'b0;
        end else begin
            run <= active ? ((&run) ? run : run + 1'b1) : '0;
            if (over) begin
                locked <= 1'b0;
                good   <= '0;
                bad    <= !ref_tick;
            end else if (ref_tick) begin
                bad <= 1'b0;
                if (bad) begin
                    good <= '0;
                end else begin
                    if (good != G_W'(LOCK_PERIODS))
                        good <= good + 1'b1;
                    locked <= (good + 1'b1) >= G_W'(LOCK_PERIODS);
                end
            end
        end
    end
endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core import synth_pkg::*; #(
    parameter int TH_W         = 8,
    parameter int LOCK_PERIODS = 8,
    parameter int COARSE_DIV   = 128,
    parameter int FINE_DIV     = 1024,
    parameter int POST_DIV     = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_stb,
    input  logic            step_fine,
    input  logic            pre_in,
    input  logic [TH_W-1:0] lock_thresh,
    output logic            mod_hi,
    output logic            frame_tick,
    output logic            ref_tick,
    output logic            pfd_up,
    output logic            pfd_dn,
    output logic            locked
);
    div_word_t word;
    logic      ld_pulse;

    synth_ser_loader u_loader (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_stb(ser_stb), .word(word), .load(ld_pulse)
    );

    synth_ref_div #(
        .COARSE_DIV(COARSE_DIV), .FINE_DIV(FINE_DIV), .POST_DIV(POST_DIV)
    ) u_ref (
        .clk(clk), .rst(rst), .load(ld_pulse), .step_fine(step_fine),
        .tick(ref_tick)
    );

    synth_swallow u_swallow (
        .clk(clk), .rst(rst), .load(ld_pulse), .pre_in(pre_in),
        .word(word), .mod_hi(mod_hi), .frame_tick(frame_tick)
    );

    synth_pfd_lock #(
        .TH_W(TH_W), .LOCK_PERIODS(LOCK_PERIODS)
    ) u_pfd (
        .clk(clk), .rst(rst), .load(ld_pulse), .ref_tick(ref_tick),
        .var_tick(frame_tick), .thresh(lock_thresh),
        .up(pfd_up), .dn(pfd_dn), .locked(locked)
    );
endmodule

// File: rtl/synth_divider_checks.sv
module synth_divider_checks #(
    parameter int TH_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            ld_pulse,
    input logic            ref_tick,
    input logic            frame_tick,
    input logic            pfd_up,
    input logic            pfd_dn,
    input logic            locked,
    input logic [TH_W-1:0] lock_thresh
);
    logic [15:0] crun;

    always_ff @(posedge clk) begin
        if (rst)
            crun <= '0;
        else if (pfd_up || pfd_dn)
            crun <= (&crun) ? crun : crun + 1'b1;
        else
            crun <= '0;
    end

    assert_pfd_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(pfd_up && pfd_dn));

    assert_lock_drop_R8: assert property (@(posedge clk) disable iff (rst)
        ((pfd_up || pfd_dn) && (crun >= 16'(lock_thresh))) |=> !locked);

    assert_load_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ld_pulse |=> (!locked && !pfd_up && !pfd_dn));

    assert_lock_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_tick));

    assert_frame_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> !frame_tick);

    assert_ref_single_R5: assert property (@(posedge clk) disable iff (rst)
        ref_tick |=> !ref_tick);
endmodule

bind synth_divider_core synth_divider_checks #(.TH_W(TH_W)) u_checks (
    .clk(clk), .rst(rst), .ld_pulse(ld_pulse), .ref_tick(ref_tick),
    .frame_tick(frame_tick), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .locked(locked), .lock_thresh(lock_thresh)
);

// File: tb/tb_synth_divider_core.sv
module tb_synth_divider_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_stb = 1'b0;
    logic       step_fine = 1'b1, pre_in = 1'b0;
    logic [7:0] lock_thresh = 8'd20;
    logic       mod_hi, frame_tick, ref_tick, pfd_up, pfd_dn, locked;

    int errors = 0, checks = 0;
    int pre_k = 0, cur_a = 0, cur_n = 1, ft_cnt = 0;
    bit exp_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    synth_divider_core dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_stb(ser_stb), .step_fine(step_fine), .pre_in(pre_in),
        .lock_thresh(lock_thresh), .mod_hi(mod_hi), .frame_tick(frame_tick),
        .ref_tick(ref_tick), .pfd_up(pfd_up), .pfd_dn(pfd_dn), .locked(locked)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) if (!rst && frame_tick) ft_cnt++;

    // scoreboard monitor: compares modulus control against queued expectation
    initial forever begin
        @(chk_ev);
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check(mod_hi == e, "R3 modulus pattern", int'(mod_hi), int'(e));
        end
    end

    // prescaler model driver: pushes expected modulus per edge
    task automatic run_pre(int edges);
        for (int i = 0; i < edges; i++) begin
            exp_q.push_back((pre_k % cur_n) < cur_a);
            pre_k++;
            ->chk_ev;
            pre_in = 1'b1;
            repeat (8) @(negedge clk);
            pre_in = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic send_word(int n, int a, bit strobe);
        logic [16:0] w;
        w = {10'(n), 7'(a)};
        for (int i = 16; i >= 0; i--) begin
            ser_data = w[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
        if (strobe) begin
            ser_stb = 1'b1;
            repeat (2) @(negedge clk);
            ser_stb = 1'b0;
        end
    endtask

    task automatic measure_ref(output int cyc);
        while (!ref_tick) @(negedge clk);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!ref_tick);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check({mod_hi, frame_tick, ref_tick, pfd_up, pfd_dn, locked} == 6'b0,
              "R9 reset outputs",
              int'({mod_hi, frame_tick, ref_tick, pfd_up, pfd_dn, locked}), 0);

        // R5 reference periods
        step_fine = 1'b1;
        measure_ref(cyc);
        check(cyc == 1024, "R5 fine period", cyc, 1024);
        step_fine = 1'b0;
        measure_ref(cyc);
        measure_ref(cyc);
        check(cyc == 1280, "R5 coarse period", cyc, 1280);
        step_fine = 1'b1;

        // R6 no frame ticks: up held, down idle
        send_word(64, 5, 1'b1);
        cur_a = 5; cur_n = 64; pre_k = 0;
        repeat (1100) @(negedge clk);
        check(pfd_up == 1'b1, "R6 up held", int'(pfd_up), 1);
        check(pfd_dn == 1'b0, "R6 down idle", int'(pfd_dn), 0);
        check(locked == 1'b0, "R7 no lock without frames", int'(locked), 0);

        // R7 matched stream locks; R3 frame count
        send_word(64, 5, 1'b1);
        pre_k = 0; ft_cnt = 0;
        check(locked == 1'b0, "R4 lock cleared", int'(locked), 0);
        run_pre(640);
        check(locked == 1'b1, "R7 matched lock", int'(locked), 1);
        check(ft_cnt == 10, "R3 frame ticks", ft_cnt, 10);

        // R2 invalid word (A > N) ignored while running
        fork
            run_pre(192);
            send_word(50, 100, 1'b1);
        join
        check(locked == 1'b1, "R2 invalid word ignored", int'(locked), 1);

        // R1 shift without strobe has no effect
        fork
            run_pre(128);
            send_word(64, 20, 1'b0);
        join
        check(locked == 1'b1, "R1 no strobe no effect", int'(locked), 1);

        // R4 valid strobe clears lock and restarts frames
        send_word(64, 20, 1'b1);
        check(locked == 1'b0, "R4 strobe clears lock", int'(locked), 0);
        check(pfd_up == 1'b0 && pfd_dn == 1'b0, "R4 detector cleared",
              int'({pfd_up, pfd_dn}), 0);
        cur_a = 20; pre_k = 0; ft_cnt = 0;
        run_pre(640);
        check(locked == 1'b1, "R7 relock after restart", int'(locked), 1);
        check(ft_cnt == 10, "R4 frames restart", ft_cnt, 10);

        // R8 small threshold drops lock
        lock_thresh = 8'd2;
        run_pre(128);
        check(locked == 1'b0, "R8 lock dropped", int'(locked), 0);
        lock_thresh = 8'd20;

        // R7 mismatched frame length never locks
        send_word(60, 20, 1'b1);
        cur_n = 60; pre_k = 0;
        run_pre(720);
        check(locked == 1'b0, "R7 mismatch no lock", int'(locked), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule